// File: doc/BRIEF.md
# Sequential Polynomial Multiplier over GF(239^m)

This block multiplies two polynomials whose coefficients are integers modulo the prime 239 and reduces the product modulo a monic polynomial of degree m. The modulus is x^m + g_{m-1}x^{m-1} + ... + g_0, and the caller supplies its m low coefficients g. A start pulse latches the operands `a`, `b` and `g`. The block then scans `b` from its highest coefficient down, and one cycle after the last step a done pulse marks a valid result `c = a*b mod g`.

Each coefficient position owns one mod-239 multiplier and one mod-239 adder/subtractor. Every iteration spends two cycles on that pair. In the first cycle the accumulator is shifted up by one place, and the overflowing x^m term is folded back through the modulus by subtraction. In the second cycle the selected coefficient of `b` times `a` is added in. A product therefore takes 2m cycles.

Top module: `gfpm_mul`

## Requirements
- R1: While reset is high and after it, `busy_o` and `done_o` are 0 and `c_o` is all zeros until the first start.
- R2: For operands whose coefficients are each in 0..238, the result equals the schoolbook product of `a` and `b` reduced modulo x^m + sum g_j x^j, with every coefficient taken mod 239. Coefficient j of every vector occupies bits [8j+7:8j].
- R3: `done_o` rises exactly 2m clock edges after the edge that samples `start_i` with the block idle, and it stays high for a single cycle.
- R4: After the done pulse, `c_o` holds its value unchanged until the next accepted start.
- R5: A `start_i` pulse while `busy_o` is high is ignored: the product in progress completes with the original operands and unchanged timing.
- R6: Every coefficient of `c_o` is always in the range 0..238.
- R7: The operands are captured at the accepted start. Changes to `a_i`, `b_i` and `g_i` while busy do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a product; taken only when idle |
| a_i | input | 8*M | Operand a, m coefficients |
| b_i | input | 8*M | Operand b, m coefficients |
| g_i | input | 8*M | Low coefficients of the monic modulus |
| c_o | output | 8*M | Product accumulator / result |
| busy_o | output | 1 | Product in progress |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
The result is due on the clock edge that lies 2m edges after the edge that samples start. The bench counts falling edges from the start strobe and requires `done_o` to appear at exactly 2m+1 falling edges for m=4 and m=8. It samples `c_o` at that falling edge and again one and three cycles later, to check the single-cycle pulse and the hold behaviour. Inputs are driven only on falling edges, so every comparison lands mid-cycle, well clear of the edge that updates the registers.

// File: rtl/gfpm_pkg.sv
package gfpm_pkg;

    localparam int unsigned PRIME = 239;
    localparam int unsigned CW    = 8;

    typedef logic [CW-1:0] coef_t;

    typedef enum logic {
        PH_REDUCE = 1'b0,
        PH_ACCUM  = 1'b1
    } phase_e;

    function automatic coef_t mod_mul(input coef_t x, input coef_t y);
        logic [2*CW-1:0] prod;
        logic [2*CW-1:0] rem;
        prod = {{CW{1'b0}}, x} * {{CW{1'b0}}, y};
        rem  = prod % (2*CW)'(PRIME);
        return rem[CW-1:0];
    endfunction

    function automatic coef_t mod_addsub(input coef_t x, input coef_t y, input logic sub);
        logic [CW:0] s;
        if (sub) begin
            s = {1'b0, x} - {1'b0, y};
            if (x < y) s = s + (CW+1)'(PRIME);
        end else begin
            s = {1'b0, x} + {1'b0, y};
            if (s >= (CW+1)'(PRIME)) s = s - (CW+1)'(PRIME);
        end
        return s[CW-1:0];
    endfunction

endpackage

// File: rtl/gfpm_cell.sv
module gfpm_cell
    import gfpm_pkg::*;
(
    input  phase_e phase,
    input  coef_t  c_top,
    input  coef_t  g_j,
    input  coef_t  b_cur,
    input  coef_t  a_j,
    input  coef_t  c_lower,
    input  coef_t  c_self,
    output coef_t  c_next
);
    coef_t mul_x, mul_y, addend, prod;
    logic  sub;

    always_comb begin
        if (phase == PH_REDUCE) begin
            mul_x  = c_top;
            mul_y  = g_j;
            addend = c_lower;
            sub    = 1'b1;
        end else begin
            mul_x  = b_cur;
            mul_y  = a_j;
            addend = c_self;
            sub    = 1'b0;
        end
        prod   = mod_mul(mul_x, mul_y);
        c_next = mod_addsub(addend, prod, sub);
    end

    always_comb begin
        if (c_lower < coef_t'(PRIME) && c_self < coef_t'(PRIME) && c_top < coef_t'(PRIME))
            a_r6_cell_range: assert (c_next < coef_t'(PRIME));
    end
endmodule

// File: rtl/gfpm_ctrl.sv
module gfpm_ctrl
    import gfpm_pkg::*;
#(
    parameter int unsigned M  = 4,
    localparam int unsigned IW = (M > 1) ? $clog2(M) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          load,
    output phase_e        phase,
    output logic [IW-1:0] iter
);
    logic last_step;

    assign load      = start && !busy;
    assign last_step = busy && (phase == PH_ACCUM) && (iter == IW'(M-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            phase <= PH_REDUCE;
            iter  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    phase <= PH_REDUCE;
                    iter  <= '0;
                end
            end else if (phase == PH_REDUCE) begin
                phase <= PH_ACCUM;
            end else begin
                phase <= PH_REDUCE;
                if (last_step) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    iter <= iter + 1'b1;
                end
            end
        end
    end

    // R3: single-cycle done pulse
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R3: done accompanies the end of busy
    a_r3_done_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    // R5: mid-run starts cannot cut a run short
    a_r5_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !last_step) |=> busy);
    // R3: iteration index stays in range
    a_r3_iter_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (iter <= IW'(M-1)));
endmodule

// File: rtl/gfpm_mul.sv
module gfpm_mul
    import gfpm_pkg::*;
#(
    parameter int unsigned M = 4,
    localparam int unsigned VW = M * CW,
    localparam int unsigned IW = (M > 1) ? $clog2(M) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [VW-1:0] a_i,
    input  logic [VW-1:0] b_i,
    input  logic [VW-1:0] g_i,
    output logic [VW-1:0] c_o,
    output logic          busy_o,
    output logic          done_o
);
    coef_t a_q [M];
    coef_t b_q [M];
    coef_t g_q [M];
    coef_t c_q [M];
    coef_t c_nx [M];

    logic          busy, done, load;
    phase_e        phase;
    logic [IW-1:0] iter;
    coef_t         b_cur;

    gfpm_ctrl #(.M(M)) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .start(start_i),
        .busy (busy),
        .done (done),
        .load (load),
        .phase(phase),
        .iter (iter)
    );

    assign b_cur = b_q[IW'(M-1) - iter];

    for (genvar j = 0; j < M; j++) begin : g_pos
        coef_t lower;
        if (j == 0) begin : g_bottom
            assign lower = '0;
        end else begin : g_upper
            assign lower = c_q[j-1];
        end

        gfpm_cell u_cell (
            .phase  (phase),
            .c_top  (c_q[M-1]),
            .g_j    (g_q[j]),
            .b_cur  (b_cur),
            .a_j    (a_q[j]),
            .c_lower(lower),
            .c_self (c_q[j]),
            .c_next (c_nx[j])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                a_q[j] <= '0;
                b_q[j] <= '0;
                g_q[j] <= '0;
                c_q[j] <= '0;
            end else if (load) begin
                a_q[j] <= a_i[j*CW +: CW];
                b_q[j] <= b_i[j*CW +: CW];
                g_q[j] <= g_i[j*CW +: CW];
                c_q[j] <= '0;
            end else if (busy) begin
                c_q[j] <= c_nx[j];
            end
        end

        assign c_o[j*CW +: CW] = c_q[j];

        // R6: accumulator coefficient always a residue mod 239
        a_r6_coef_range: assert property (@(posedge clk) disable iff (rst)
            c_q[j] < coef_t'(PRIME));
        // R7: latched operands frozen during a run
        a_r7_operands_frozen: assert property (@(posedge clk) disable iff (rst)
            busy |=> ($stable(a_q[j]) && $stable(b_q[j]) && $stable(g_q[j])));
    end

    assign busy_o = busy;
    assign done_o = done;

    // R4: result held while idle and no start
    a_r4_result_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start_i) |=> $stable(c_o));
    // R1: an accepted start clears the accumulator
    a_r1_clear_on_start: assert property (@(posedge clk) disable iff (rst)
        load |=> (c_o == '0));
endmodule

// File: tb/gfpm_mul_bench.sv
module gfpm_mul_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        s4 = 1'b0, s8 = 1'b0;
    logic [31:0] a4 = '0, b4 = '0, g4 = '0;
    logic [63:0] a8 = '0, b8 = '0, g8 = '0;
    logic [31:0] c4;
    logic [63:0] c8;
    logic        busy4, done4, busy8, done8;

    int checks = 0;
    int fails  = 0;

    gfpm_mul #(.M(4)) u_gfpm_mul (
        .clk(clk), .rst(rst), .start_i(s4), .a_i(a4), .b_i(b4), .g_i(g4),
        .c_o(c4), .busy_o(busy4), .done_o(done4));

    gfpm_mul #(.M(8)) u_gfpm_mul8 (
        .clk(clk), .rst(rst), .start_i(s8), .a_i(a8), .b_i(b8), .g_i(g8),
        .c_o(c8), .busy_o(busy8), .done_o(done8));

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_mul(input int m, input logic [63:0] a,
                                            input logic [63:0] b, input logic [63:0] g);
        int pr [16];
        logic [63:0] r;
        for (int k = 0; k < 16; k++) pr[k] = 0;
        for (int i = 0; i < m; i++)
            for (int j = 0; j < m; j++)
                pr[i+j] = (pr[i+j] + int'(a[8*i +: 8]) * int'(b[8*j +: 8])) % 239;
        for (int k = 2*m-2; k >= m; k--)
            for (int j = 0; j < m; j++)
                pr[k-m+j] = (pr[k-m+j] + 239 - (pr[k] * int'(g[8*j +: 8])) % 239) % 239;
        r = '0;
        for (int j = 0; j < m; j++) r[8*j +: 8] = 8'(pr[j]);
        return r;
    endfunction

    function automatic logic [63:0] rnd_vec(input int m);
        logic [63:0] v = '0;
        for (int j = 0; j < m; j++) v[8*j +: 8] = 8'($urandom % 239);
        return v;
    endfunction

    function automatic bit in_range(input int m, input logic [63:0] v);
        for (int j = 0; j < m; j++) if (v[8*j +: 8] > 8'd238) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [63:0] cur_c(input int m);
        return (m == 4) ? {32'd0, c4} : c8;
    endfunction

    function automatic logic cur_done(input int m);
        return (m == 4) ? done4 : done8;
    endfunction

    task automatic drive(input int m, input logic st, input logic [63:0] a,
                         input logic [63:0] b, input logic [63:0] g);
        if (m == 4) begin s4 = st; a4 = a[31:0]; b4 = b[31:0]; g4 = g[31:0]; end
        else        begin s8 = st; a8 = a;       b8 = b;       g8 = g;       end
    endtask

    // disturb: R5/R7 stimulus while busy
    task automatic run(input int m, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] g, input bit disturb);
        logic [63:0] exp, held;
        int lat;
        exp = ref_mul(m, a, b, g);
        @(negedge clk);
        drive(m, 1'b1, a, b, g);
        lat = 0;
        forever begin
            @(negedge clk);
            lat++;
            if (lat == 1) drive(m, 1'b0, a, b, g);
            if (disturb && lat == 3) drive(m, 1'b1, rnd_vec(m), rnd_vec(m), rnd_vec(m));
            if (disturb && lat == 4) drive(m, 1'b0, rnd_vec(m), rnd_vec(m), rnd_vec(m));
            if (cur_done(m) || lat > 4*m) break;
        end
        drive(m, 1'b0, '0, '0, '0);
        chk(lat == 2*m+1, disturb ? "R3/R5 latency under mid-run start" : "R3 done latency",
            64'(lat), 64'(2*m+1));
        chk(cur_c(m) == exp, disturb ? "R7/R5 result with disturbed inputs" : "R2 product",
            cur_c(m), exp);
        chk(in_range(m, cur_c(m)), "R6 coefficient range", cur_c(m), exp);
        held = cur_c(m);
        @(negedge clk);
        chk(cur_done(m) == 1'b0, "R3 done single cycle", 64'(cur_done(m)), 64'd0);
        repeat (2) @(negedge clk);
        chk(cur_c(m) == held, "R4 result hold", cur_c(m), held);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        logic [63:0] ones;
        repeat (3) @(negedge clk);
        chk(busy4 == 0 && done4 == 0 && c4 == '0, "R1 reset state m4", {32'd0, c4}, 64'd0);
        chk(busy8 == 0 && done8 == 0 && c8 == '0, "R1 reset state m8", c8, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy4 == 0 && c4 == '0, "R1 idle after reset", {32'd0, c4}, 64'd0);

        for (int mi = 0; mi < 2; mi++) begin
            int m = (mi == 0) ? 4 : 8;
            ones = '0;
            for (int j = 0; j < m; j++) ones[8*j +: 8] = 8'd238;
            run(m, '0, '0, '0, 1'b0);
            run(m, ones, ones, ones, 1'b0);
            run(m, 64'h1, ones, ones, 1'b0);
            run(m, ones, 64'(1) << (8*(m-1)), ones, 1'b0);
            run(m, 64'(1) << (8*(m-1)), 64'(1) << (8*(m-1)), rnd_vec(m), 1'b0);
            for (int k = 0; k < 20; k++)
                run(m, rnd_vec(m), rnd_vec(m), rnd_vec(m), 1'b1);
            for (int k = 0; k < 300; k++)
                run(m, rnd_vec(m), rnd_vec(m), rnd_vec(m), 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule